// File: doc/BRIEF.md
# Dual-Plane Flash Page Program Sequencer

This block programs one page in each of two planes of a byte-wide raw NAND flash device as a single operation. A host supplies a column address, a row address and a per-plane byte count, pulses `start`, and streams the page data through a valid/ready byte interface. The sequencer drives the command, address and data cycles on the flash bus and watches the ready/busy line. At the end it reads the device status and reports pass, fail or a timeout fault.

The operation has two plane phases. The first phase opens with setup command 80h, sends five address cycles and the data for plane 0, and closes with the intermediate command 11h. It then waits out a short busy interval. The second phase opens with 81h, repeats the addresses with the plane-select row bit set, sends the plane 1 data and closes with the program confirm 10h. After the long program busy interval ends, the sequencer issues the status command 70h, strobes one read and decodes bit 0 of the status byte.

Each bus cycle lasts one clock, with a write strobe `nf_we` or a read strobe `nf_re` held high for that cycle. Every output is registered.

Top module: `dp_prog_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `busy`, `done`, `s_ready`, `nf_we`, `nf_re`, `nf_cle`, `nf_ale` and all four result flags are 0.
- R2: The first phase emits, one write strobe each: command 80h (`nf_cle`=1), then five address cycles (`nf_ale`=1) in the order column[7:0], {4'b0, column[11:8]}, row[7:0], row[15:8], {7'b0, row[16]}, then `byte_cnt` data bytes (`nf_cle`=`nf_ale`=0), then command 11h.
- R3: The row bit at position 6 (flash address bit A18) is forced to 0 in the phase-0 addresses and to 1 in the phase-1 addresses. Every other address bit equals the host value latched at `start`.
- R4: After 11h the sequencer ignores `nf_rdy` for GUARD cycles and then waits for it to go high. It then emits 81h, the five address cycles, `byte_cnt` further data bytes and command 10h.
- R5: A data byte is transferred only in a cycle where `s_valid` and `s_ready` are both high. `s_ready` is high only during the data part of a phase. A stalled cycle produces no write strobe.
- R6: When the program busy interval after 10h ends, the sequencer emits 70h, one read strobe, and samples `nf_din` while `nf_re` is high. A status bit 0 of 0 sets `prog_pass`; a status bit 0 of 1 sets `prog_fail`.
- R7: Between 11h and 81h no command other than 70h or FFh is issued. If `nf_rdy` stays low for DBSY_TMO cycles after the guard, the sequencer issues FFh, sets `flt_dbsy` and ends without a second phase.
- R8: If `nf_rdy` stays low for PROG_TMO cycles after the guard following 10h, the sequencer sets `flt_prog` and ends without issuing 70h.
- R9: A `byte_cnt` of 0 produces no data cycles: each phase goes directly from its fifth address cycle to its closing command.
- R10: `busy` rises the cycle after an accepted `start` and falls together with a one-cycle `done` pulse. A `start` that arrives while `busy` is high is ignored.
- R11: `nf_cle` and `nf_ale` are never high together, and `nf_we` and `nf_re` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a dual-plane program; accepted only when idle |
| col_addr | input | 12 | Column address, latched at start |
| row_addr | input | ROW_W (17) | Row address; bit 6 is replaced by the plane number |
| byte_cnt | input | CNT_W (12) | Data bytes per plane phase |
| s_valid | input | 1 | Host data byte valid |
| s_data | input | 8 | Host data byte |
| s_ready | output | 1 | Sequencer accepts a data byte this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| prog_pass | output | 1 | Status bit 0 read as 0 |
| prog_fail | output | 1 | Status bit 0 read as 1 |
| flt_dbsy | output | 1 | Timed out after the intermediate command |
| flt_prog | output | 1 | Timed out after the program confirm |
| nf_cle | output | 1 | Command latch enable for the current cycle |
| nf_ale | output | 1 | Address latch enable for the current cycle |
| nf_we | output | 1 | Write strobe, one cycle per byte |
| nf_re | output | 1 | Read strobe |
| nf_dout | output | 8 | Byte driven to the flash |
| nf_din | input | 8 | Byte read from the flash |
| nf_rdy | input | 1 | Flash ready/busy, high when ready |

## Verification
The bench goes after these corner cases:

- **Plane bit.** A row address with bit 6 already set is used. A sequencer that passes the host row through unchanged would emit the wrong plane in phase 0.
- **Intermediate busy timeout.** The bench holds the flash busy past the first timeout. A design that got this wrong would either hang or continue with 81h, where FFh and the fault flag are expected.
- **Program busy timeout.** A stuck program busy is checked for a stray 70h.
- **Zero byte count.** A count of 0 would underflow a naive down-counter and send thousands of bytes.
- **Stalls and restarts.** Gaps in `s_valid` would expose a sequencer that strobes on stalled cycles. A `start` pulse in the middle of an operation would expose one that restarts.

// File: rtl/dpp_pkg.sv
package dpp_pkg;

  localparam logic [7:0] OP_SETUP_P0 = 8'h80;
  localparam logic [7:0] OP_SETUP_P1 = 8'h81;
  localparam logic [7:0] OP_MID      = 8'h11;
  localparam logic [7:0] OP_CONFIRM  = 8'h10;
  localparam logic [7:0] OP_STATUS   = 8'h70;
  localparam logic [7:0] OP_RESET    = 8'hFF;

  typedef enum logic [3:0] {
    S_IDLE,
    S_SETUP,
    S_ADDR,
    S_DATA,
    S_CLOSE,
    S_WAIT,
    S_STCMD,
    S_STRD,
    S_STCAP,
    S_RESET
  } seq_st_t;

endpackage

// File: rtl/dpp_addr_gen.sv
module dpp_addr_gen #(
  parameter int COL_W     = 12,
  parameter int ROW_W     = 17,
  parameter int PLANE_BIT = 6
) (
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] row,
  input  logic             plane,
  input  logic [2:0]       idx,
  output logic [7:0]       abyte
);

  logic [ROW_W-1:0] row_p;
  logic [15:0]      cpad;
  logic [23:0]      rpad;

  always_comb begin
    row_p            = row;
    row_p[PLANE_BIT] = plane;
  end

  assign cpad = 16'(col);
  assign rpad = 24'(row_p);

  always_comb begin
    case (idx)
      3'd0:    abyte = cpad[7:0];
      3'd1:    abyte = cpad[15:8];
      3'd2:    abyte = rpad[7:0];
      3'd3:    abyte = rpad[15:8];
      default: abyte = rpad[23:16];
    endcase
  end

endmodule

// File: rtl/dpp_busy_timer.sv
module dpp_busy_timer #(
  parameter int GUARD = 2,
  parameter int TMO   = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic rdy,
  output logic fin,
  output logic tmo
);

  localparam int LIM = GUARD + TMO;
  localparam int TW  = $clog2(LIM + 1);

  logic          run;
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      cnt <= '0;
      fin <= 1'b0;
      tmo <= 1'b0;
    end else begin
      fin <= 1'b0;
      tmo <= 1'b0;
      if (start) begin
        run <= 1'b1;
        cnt <= '0;
      end else if (run) begin
        if (cnt >= TW'(GUARD) && rdy) begin
          fin <= 1'b1;
          run <= 1'b0;
        end else if (cnt == TW'(LIM - 1)) begin
          tmo <= 1'b1;
          run <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_TMR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(fin && tmo)); // R8

  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < TW'(LIM))); // R7

endmodule

// File: rtl/dp_prog_seq.sv
module dp_prog_seq
  import dpp_pkg::*;
#(
  parameter int COL_W     = 12,
  parameter int ROW_W     = 17,
  parameter int CNT_W     = 12,
  parameter int PLANE_BIT = 6,
  parameter int GUARD     = 2,
  parameter int DBSY_TMO  = 40,
  parameter int PROG_TMO  = 200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] col_addr,
  input  logic [ROW_W-1:0] row_addr,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic             s_valid,
  input  logic [7:0]       s_data,
  output logic             s_ready,
  output logic             busy,
  output logic             done,
  output logic             prog_pass,
  output logic             prog_fail,
  output logic             flt_dbsy,
  output logic             flt_prog,
  output logic             nf_cle,
  output logic             nf_ale,
  output logic             nf_we,
  output logic             nf_re,
  output logic [7:0]       nf_dout,
  input  logic [7:0]       nf_din,
  input  logic             nf_rdy
);

  localparam int PB_IDX = 2 + PLANE_BIT / 8;
  localparam int PB_POS = PLANE_BIT % 8;

  seq_st_t          st;
  logic             phase;
  logic [2:0]       aidx;
  logic [CNT_W-1:0] dcnt;
  logic [CNT_W-1:0] cnt_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic [7:0]       abyte;
  logic [1:0]       tmr_start;
  logic [1:0]       tmr_fin;
  logic [1:0]       tmr_tmo;
  logic             din_unused;

  assign din_unused = ^nf_din[7:1];
  assign s_ready    = (st == S_DATA);

  dpp_addr_gen #(
    .COL_W(COL_W), .ROW_W(ROW_W), .PLANE_BIT(PLANE_BIT)
  ) u_addr (
    .col(col_q), .row(row_q), .plane(phase), .idx(aidx), .abyte(abyte)
  );

  for (genvar g = 0; g < 2; g++) begin : g_tmr
    localparam int TMO_G = (g == 0) ? DBSY_TMO : PROG_TMO;
    assign tmr_start[g] = (st == S_CLOSE) && (phase == 1'(g));
    dpp_busy_timer #(.GUARD(GUARD), .TMO(TMO_G)) u_tmr (
      .clk(clk), .rst(rst), .start(tmr_start[g]), .rdy(nf_rdy),
      .fin(tmr_fin[g]), .tmo(tmr_tmo[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      phase     <= 1'b0;
      aidx      <= '0;
      dcnt      <= '0;
      cnt_q     <= '0;
      col_q     <= '0;
      row_q     <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      prog_pass <= 1'b0;
      prog_fail <= 1'b0;
      flt_dbsy  <= 1'b0;
      flt_prog  <= 1'b0;
      nf_cle    <= 1'b0;
      nf_ale    <= 1'b0;
      nf_we     <= 1'b0;
      nf_re     <= 1'b0;
      nf_dout   <= '0;
    end else begin
      nf_we  <= 1'b0;
      nf_cle <= 1'b0;
      nf_ale <= 1'b0;
      nf_re  <= 1'b0;
      done   <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            col_q     <= col_addr;
            row_q     <= row_addr;
            cnt_q     <= byte_cnt;
            phase     <= 1'b0;
            busy      <= 1'b1;
            prog_pass <= 1'b0;
            prog_fail <= 1'b0;
            flt_dbsy  <= 1'b0;
            flt_prog  <= 1'b0;
            st        <= S_SETUP;
          end
        end
        S_SETUP: begin
          nf_we   <= 1'b1;
          nf_cle  <= 1'b1;
          nf_dout <= phase ? OP_SETUP_P1 : OP_SETUP_P0;
          aidx    <= '0;
          st      <= S_ADDR;
        end
        S_ADDR: begin
          nf_we   <= 1'b1;
          nf_ale  <= 1'b1;
          nf_dout <= abyte;
          aidx    <= aidx + 1'b1;
          if (aidx == 3'd4) begin
            dcnt <= '0;
            st   <= (cnt_q == '0) ? S_CLOSE : S_DATA;
          end
        end
        S_DATA: begin
          if (s_valid) begin
            nf_we   <= 1'b1;
            nf_dout <= s_data;
            dcnt    <= dcnt + 1'b1;
            if (dcnt == (cnt_q - CNT_W'(1))) st <= S_CLOSE;
          end
        end
        S_CLOSE: begin
          nf_we   <= 1'b1;
          nf_cle  <= 1'b1;
          nf_dout <= phase ? OP_CONFIRM : OP_MID;
          st      <= S_WAIT;
        end
        S_WAIT: begin
          if (tmr_fin[phase]) begin
            if (!phase) begin
              phase <= 1'b1;
              st    <= S_SETUP;
            end else begin
              st <= S_STCMD;
            end
          end else if (tmr_tmo[phase]) begin
            if (!phase) begin
              flt_dbsy <= 1'b1;
              st       <= S_RESET;
            end else begin
              flt_prog <= 1'b1;
              busy     <= 1'b0;
              done     <= 1'b1;
              st       <= S_IDLE;
            end
          end
        end
        S_RESET: begin
          nf_we   <= 1'b1;
          nf_cle  <= 1'b1;
          nf_dout <= OP_RESET;
          busy    <= 1'b0;
          done    <= 1'b1;
          st      <= S_IDLE;
        end
        S_STCMD: begin
          nf_we   <= 1'b1;
          nf_cle  <= 1'b1;
          nf_dout <= OP_STATUS;
          st      <= S_STRD;
        end
        S_STRD: begin
          nf_re <= 1'b1;
          st    <= S_STCAP;
        end
        S_STCAP: begin
          prog_fail <= nf_din[0];
          prog_pass <= ~nf_din[0];
          busy      <= 1'b0;
          done      <= 1'b1;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // Tracks, from the bus itself, whether 11h has been sent and 81h not yet.
  logic mid_seen;
  always_ff @(posedge clk) begin
    if (rst || done) mid_seen <= 1'b0;
    else if (nf_we && nf_cle && nf_dout == OP_MID) mid_seen <= 1'b1;
    else if (nf_we && nf_cle && nf_dout == OP_SETUP_P1) mid_seen <= 1'b0;
  end

  AST_MID_CMDS: assert property (@(posedge clk) disable iff (rst)
    (mid_seen && nf_we && nf_cle) |->
      (nf_dout == OP_SETUP_P1 || nf_dout == OP_STATUS || nf_dout == OP_RESET)); // R7

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(nf_cle && nf_ale) && !(nf_we && nf_re)); // R11

  AST_PLANE_BIT: assert property (@(posedge clk) disable iff (rst)
    (nf_we && nf_ale && aidx == 3'(PB_IDX + 1)) |-> (nf_dout[PB_POS] == phase)); // R3

  AST_DATA_HANDSHAKE: assert property (@(posedge clk) disable iff (rst)
    (nf_we && !nf_cle && !nf_ale) |-> $past(s_valid && s_ready)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R10

endmodule

// File: tb/sim_dp_prog_seq.sv
module sim_dp_prog_seq;

  localparam int CLK_PER = 10;
  localparam int GUARD   = 2;
  localparam int DBSY_T  = 40;
  localparam int PROG_T  = 200;

  typedef struct packed {
    logic [11:0] col;
    logic [16:0] row;
    logic [11:0] n;
    logic        fbit;
    logic [11:0] dbsy;
    logic [11:0] prog;
    logic [1:0]  kind;   // 0 normal, 1 dbsy timeout, 2 prog timeout
    logic        gap;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VT [NV] = '{
    '{12'h000, 17'h00000, 12'd4, 1'b0, 12'd3,    12'd10,   2'd0, 1'b0},
    '{12'hABC, 17'h1FFFF, 12'd7, 1'b1, 12'd5,    12'd30,   2'd0, 1'b1},
    '{12'h5A5, 17'h10040, 12'd1, 1'b0, 12'd1,    12'd1,    2'd0, 1'b1},
    '{12'hFFF, 17'h0A5BF, 12'd3, 1'b0, 12'd1000, 12'd10,   2'd1, 1'b0},
    '{12'h123, 17'h12345, 12'd2, 1'b0, 12'd4,    12'd1000, 2'd2, 1'b0},
    '{12'h800, 17'h00001, 12'd0, 1'b1, 12'd2,    12'd5,    2'd0, 1'b1}
  };

  logic        clk = 0, rst = 1, start = 0;
  logic [11:0] col_addr = 0;
  logic [16:0] row_addr = 0;
  logic [11:0] byte_cnt = 0;
  logic        s_valid = 0;
  logic [7:0]  s_data = 0;
  logic        s_ready, busy, done, prog_pass, prog_fail, flt_dbsy, flt_prog;
  logic        nf_cle, nf_ale, nf_we, nf_re;
  logic [7:0]  nf_dout, nf_din;
  logic        nf_rdy = 1;

  int checks = 0, fails = 0;
  int cyc = 0;
  int nlog = 0, nexp = 0, ndone = 0, nacc = 0;
  int rdy_left = 0;
  int dbsy_len = 1, prog_len = 1;
  logic cur_fail = 0, gap_mode = 0, acc_clr = 0;
  logic [9:0] logq [0:1023];
  logic [9:0] expq [0:1023];

  dp_prog_seq #(.GUARD(GUARD), .DBSY_TMO(DBSY_T), .PROG_TMO(PROG_T)) u0 (
    .clk(clk), .rst(rst), .start(start), .col_addr(col_addr),
    .row_addr(row_addr), .byte_cnt(byte_cnt), .s_valid(s_valid),
    .s_data(s_data), .s_ready(s_ready), .busy(busy), .done(done),
    .prog_pass(prog_pass), .prog_fail(prog_fail), .flt_dbsy(flt_dbsy),
    .flt_prog(flt_prog), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we(nf_we),
    .nf_re(nf_re), .nf_dout(nf_dout), .nf_din(nf_din), .nf_rdy(nf_rdy)
  );

  always #(CLK_PER/2) clk = ~clk;

  assign nf_din = nf_re ? {1'b0, 1'b1, 5'b0, cur_fail} : 8'h00;

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 37 + 92) & 255);
  endfunction

  function automatic logic [7:0] abyte(input logic [11:0] c, input logic [16:0] r,
                                       input logic p, input int i);
    logic [16:0] rp;
    logic [23:0] rz;
    rp = r;
    rp[6] = p;
    rz = {7'b0, rp};
    case (i)
      0: return c[7:0];
      1: return {4'b0, c[11:8]};
      2: return rz[7:0];
      3: return rz[15:8];
      default: return rz[23:16];
    endcase
  endfunction

  // Accept counter on the host stream
  always @(posedge clk) begin
    if (acc_clr) nacc <= 0;
    else if (s_valid && s_ready) nacc <= nacc + 1;
  end

  // Flash bus model, logger, feeder
  always @(negedge clk) begin
    cyc <= cyc + 1;
    s_data  <= pat(nacc);
    s_valid <= gap_mode ? ((cyc % 3) != 0) : 1'b1;
    if (done) ndone <= ndone + 1;
    if (nf_we) begin
      logq[nlog] <= {nf_cle, nf_ale, nf_dout};
      nlog <= nlog + 1;
    end
    if (nf_we && nf_cle && nf_dout == 8'h11) begin
      nf_rdy <= 1'b0; rdy_left <= dbsy_len;
    end else if (nf_we && nf_cle && nf_dout == 8'h10) begin
      nf_rdy <= 1'b0; rdy_left <= prog_len;
    end else if (nf_we && nf_cle && nf_dout == 8'hFF) begin
      nf_rdy <= 1'b1; rdy_left <= 0;
    end else if (rdy_left > 1) begin
      rdy_left <= rdy_left - 1;
    end else if (rdy_left == 1) begin
      rdy_left <= 0; nf_rdy <= 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic c, input logic a, input logic [7:0] b);
    expq[nexp] = {c, a, b};
    nexp++;
  endtask

  task automatic build_phase(input vec_t v, input logic p);
    push(1, 0, p ? 8'h81 : 8'h80);
    for (int i = 0; i < 5; i++) push(0, 1, abyte(v.col, v.row, p, i));
    for (int i = 0; i < int'(v.n); i++) push(0, 0, pat(int'(p) * int'(v.n) + i));
    push(1, 0, p ? 8'h10 : 8'h11);
  endtask

  task automatic run_op(input vec_t v, input bit restart, input string tag);
    int mism, first, w, exp_acc;
    @(negedge clk);
    nexp = 0; nlog = 0; ndone = 0;
    cur_fail = v.fbit; gap_mode = v.gap;
    dbsy_len = int'(v.dbsy); prog_len = int'(v.prog);
    col_addr = v.col; row_addr = v.row; byte_cnt = v.n;
    acc_clr = 1; start = 1;
    @(negedge clk);
    acc_clr = 0; start = 0;
    chk(busy == 1'b1, {tag, " R10 busy after start"}, busy, 1);
    build_phase(v, 1'b0);
    exp_acc = int'(v.n);
    if (v.kind == 2'd1) push(1, 0, 8'hFF);
    else begin
      build_phase(v, 1'b1);
      exp_acc = 2 * int'(v.n);
      if (v.kind == 2'd0) push(1, 0, 8'h70);
    end
    w = 0;
    while (!done && w < 5000) begin
      if (restart && w == 6) begin start = 1; col_addr = ~v.col; end
      else start = 0;
      @(negedge clk);
      w++;
    end
    start = 0;
    chk(w < 5000, {tag, " R10 done reached"}, w, 5000);
    @(negedge clk);
    @(negedge clk);
    chk(nlog == nexp, {tag, " R2 R4 bus cycle count"}, nlog, nexp);
    mism = 0; first = -1;
    for (int i = 0; i < nexp && i < nlog; i++)
      if (logq[i] !== expq[i]) begin mism++; if (first < 0) first = i; end
    if (first >= 0)
      chk(0, {tag, " R2 R3 R4 bus sequence"}, int'(logq[first]), int'(expq[first]));
    else
      chk(1, {tag, " R2 R3 R4 bus sequence"}, 0, 0);
    chk(nacc == exp_acc, {tag, " R5 R9 bytes accepted"}, nacc, exp_acc);
    chk(ndone == 1, {tag, " R10 single done"}, ndone, 1);
    chk(busy == 0 && s_ready == 0, {tag, " R5 idle after op"}, {busy, s_ready}, 0);
    case (v.kind)
      2'd0: chk({prog_pass, prog_fail, flt_dbsy, flt_prog} == {~v.fbit, v.fbit, 2'b00},
                {tag, " R6 status result"}, {prog_pass, prog_fail, flt_dbsy, flt_prog},
                {~v.fbit, v.fbit, 2'b00});
      2'd1: chk({prog_pass, prog_fail, flt_dbsy, flt_prog} == 4'b0010,
                {tag, " R7 dbsy timeout flags"}, {prog_pass, prog_fail, flt_dbsy, flt_prog}, 4'b0010);
      default: chk({prog_pass, prog_fail, flt_dbsy, flt_prog} == 4'b0001,
                {tag, " R8 prog timeout flags"}, {prog_pass, prog_fail, flt_dbsy, flt_prog}, 4'b0001);
    endcase
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, s_ready, nf_we, nf_re, nf_cle, nf_ale} == 7'b0, "R1 during reset",
        {busy, done, s_ready, nf_we, nf_re, nf_cle, nf_ale}, 0);
    rst = 0;
    @(negedge clk);
    chk({busy, done, s_ready, nf_we, nf_re, nf_cle, nf_ale,
         prog_pass, prog_fail, flt_dbsy, flt_prog} == 11'b0, "R1 after reset",
        {busy, done, s_ready, nf_we, nf_re, nf_cle, nf_ale,
         prog_pass, prog_fail, flt_dbsy, flt_prog}, 0);
    for (int k = 0; k < NV; k++) run_op(VT[k], 1'b0, $sformatf("vec%0d", k));
    // Directed: start pulse in mid-operation is ignored (R10)
    run_op(VT[1], 1'b1, "restart R10");
    // Directed: timeout fault cleared by the next good operation (R6)
    run_op(VT[3], 1'b0, "dbsy again R7");
    run_op(VT[0], 1'b0, "recover R6");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PER * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog R10 actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule